// File: doc/BRIEF.md
# Register access sequencer over I2C

This block sits on the host side and turns single-byte register requests into byte-level commands for an I2C master that lies underneath it. Each request carries a direction, an 8-bit register number and, for writes, one data byte. The block talks to one target at a fixed 7-bit bus address. For each request it returns one response that holds a read byte and an error flag.

A write goes out as one bus transfer. A read is split into two transfers: the register number is sent in a write that ends in STOP, and the data byte is then fetched by a separate read transfer. The block never uses a repeated START. After every read transfer, it holds off the next write transfer for a guard time that is set in clock cycles. If a read fails, or returns all ones, the block tries it again, up to a fixed number of attempts. Reads of the streaming data register get a single attempt only.

The master below accepts one command at a time on a valid/ready handshake and reports completion with a done pulse. The done pulse carries a NACK flag and, for a read, the byte received.

Top module: `secreg_i2c_seq`

## Requirements
- R1: A write request issues the commands START, WRITE 0x40, WRITE register, WRITE data, STOP in that order. The op codes are START=0, WRITE=1, READ=2, STOP=3, and 0x40 is the 7-bit target address 0x20 with R/W=0. A command that is offered but not yet accepted is held stable.
- R2: Each read attempt issues START, WRITE 0x40, WRITE register, STOP, then START, WRITE 0x41, READ, STOP. Every START after the first follows a STOP, so no repeated START is ever sent.
- R3: After the STOP of a read transfer completes, the START of the next write transfer is not accepted until at least GUARD_US×CLK_MHZ clock cycles have passed. This includes the address phase of a following read.
- R4: A read attempt that returns 0xFF, or that fails, is repeated. At most 3 attempts are made, and the outcome of the last attempt is the one reported.
- R5: A read of register 0x05 gets exactly one attempt, whatever it returns.
- R6: A read whose final attempt failed reports data 0xFF.
- R7: A failed final read of register 0x00 reports no error. A failed final read of any other register sets the error flag. A read that succeeds with 0xFF after all attempts reports no error.
- R8: A NACK on any written byte ends that transfer: STOP is the next command. A NACK in a write request sets the error flag, with data 0x00. A NACK in the address phase of a read does not stop the read transfer from following.
- R9: The request port is ready only when the block is idle. Exactly one response is returned per request, and the response is valid for a single cycle.
- R10: After reset the request port is ready, and no response or command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register number |
| req_wdata | input | 8 | Data byte for a write |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 8 | Read result (0x00 for writes) |
| rsp_err | output | 1 | Request failed |
| cmd_valid | output | 1 | Command offered to the bus master |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_op | output | 2 | Command code: START=0, WRITE=1, READ=2, STOP=3 |
| cmd_byte | output | 8 | Byte for a WRITE command |
| mst_done | input | 1 | Bus master finished the accepted command |
| mst_nack | input | 1 | Finished command was not acknowledged or failed |
| mst_rdata | input | 8 | Byte received by a READ command |

## Verification
A command is offered in the cycle after the previous one completes, and it stays offered until it is accepted. A response appears two cycles after the final read STOP completes, or one cycle after the STOP of a write completes. The bench therefore never waits for a fixed latency. Its master model logs each command at the moment it accepts it, and compares it there with the next entry of an expected queue. Responses are compared at the falling edge where the single-cycle pulse is seen. The guard gap is measured in cycles, from the completion of a read STOP to the acceptance of the next START that carries 0x40, and compared with GUARD_US×CLK_MHZ.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    K_WR   = 2'd0,
    K_RADR = 2'd1,
    K_RDAT = 2'd2
  } xfer_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_START, S_SLA, S_REG, S_DAT,
    S_RDB, S_STOP, S_DECIDE, S_RESP
  } seq_state_e;
endpackage

// File: rtl/secreg_guard.sv
module secreg_guard #(
  parameter int CYC = 12500,
  localparam int W = $clog2(CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic idle
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (arm)        cnt <= W'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  AST_GUARD_ONLY_AFTER_ARM: assert property (@(posedge clk) disable iff (rst)
    $fell(idle) |-> $past(arm)); // R3
endmodule

// File: rtl/secreg_retry.sv
module secreg_retry #(
  parameter int         TRIES    = 3,
  parameter logic [7:0] FIFO_REG = 8'h05,
  parameter logic [7:0] ACC_REG  = 8'h00,
  localparam int TW = $clog2(TRIES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       step,
  input  logic [7:0] reg_addr,
  input  logic       fail,
  input  logic [7:0] rbyte,
  output logic       again,
  output logic [7:0] final_data,
  output logic       final_err
);
  logic [TW-1:0] tries;

  always_ff @(posedge clk) begin
    if (rst || clr) tries <= '0;
    else if (step)  tries <= tries + 1'b1;
  end

  always_comb begin
    final_data = fail ? 8'hFF : rbyte;
    final_err  = fail && (reg_addr != ACC_REG);
    again      = (final_data == 8'hFF) && (reg_addr != FIFO_REG) &&
                 ((int'(tries) + 1) < TRIES);
  end

  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(tries) <= TRIES); // R4
  AST_FIFO_ONCE: assert property (@(posedge clk) disable iff (rst)
    (step && reg_addr == FIFO_REG) |-> (tries == '0)); // R5
endmodule

// File: rtl/secreg_xfer.sv
module secreg_xfer
  import secreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20,
  parameter logic [7:0] ACC_REG  = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       rsp_err,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_byte,
  input  logic       mst_done,
  input  logic       mst_nack,
  input  logic [7:0] mst_rdata,
  input  logic       guard_idle,
  output logic       guard_arm,
  output logic       retry_clr,
  output logic       retry_step,
  output logic [7:0] retry_reg,
  output logic       retry_fail,
  output logic [7:0] retry_rbyte,
  input  logic       retry_again,
  input  logic [7:0] retry_data,
  input  logic       retry_err
);
  localparam logic [7:0] SLA_W = {DEV_ADDR, 1'b0};
  localparam logic [7:0] SLA_R = {DEV_ADDR, 1'b1};

  seq_state_e st;
  xfer_kind_e kind;
  logic       pend, fail, wr_q;
  logic [7:0] reg_q, dat_q, rbyte_q, rdata_q;
  logic       err_q;
  logic       hs, op_done, is_cmd;

  always_comb begin
    cmd_op   = OP_START;
    cmd_byte = 8'h00;
    is_cmd   = 1'b1;
    case (st)
      S_START: cmd_op = OP_START;
      S_SLA:   begin cmd_op = OP_WRITE; cmd_byte = (kind == K_RDAT) ? SLA_R : SLA_W; end
      S_REG:   begin cmd_op = OP_WRITE; cmd_byte = reg_q; end
      S_DAT:   begin cmd_op = OP_WRITE; cmd_byte = dat_q; end
      S_RDB:   cmd_op = OP_READ;
      S_STOP:  cmd_op = OP_STOP;
      default: is_cmd = 1'b0;
    endcase
    cmd_valid = is_cmd && !pend;
  end

  assign hs        = cmd_valid && cmd_ready;
  assign op_done   = pend && mst_done;
  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

  assign guard_arm   = (st == S_STOP) && op_done && (kind == K_RDAT);
  assign retry_clr   = (st == S_IDLE) && req_valid;
  assign retry_step  = (st == S_DECIDE);
  assign retry_reg   = reg_q;
  assign retry_fail  = fail;
  assign retry_rbyte = rbyte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      kind    <= K_WR;
      pend    <= 1'b0;
      fail    <= 1'b0;
      wr_q    <= 1'b0;
      reg_q   <= 8'h00;
      dat_q   <= 8'h00;
      rbyte_q <= 8'h00;
      rdata_q <= 8'h00;
      err_q   <= 1'b0;
    end else begin
      if (hs)           pend <= 1'b1;
      else if (op_done) pend <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q  <= req_write;
          reg_q <= req_addr;
          dat_q <= req_wdata;
          kind  <= req_write ? K_WR : K_RADR;
          st    <= S_PRE;
        end
        S_PRE: if (guard_idle) st <= S_START;
        S_START: if (op_done) begin
          fail <= 1'b0;
          st   <= S_SLA;
        end
        S_SLA: if (op_done) begin
          if (mst_nack) begin fail <= 1'b1; st <= S_STOP; end
          else st <= (kind == K_RDAT) ? S_RDB : S_REG;
        end
        S_REG: if (op_done) begin
          if (mst_nack) begin fail <= 1'b1; st <= S_STOP; end
          else st <= (kind == K_WR) ? S_DAT : S_STOP;
        end
        S_DAT: if (op_done) begin
          fail <= mst_nack;
          st   <= S_STOP;
        end
        S_RDB: if (op_done) begin
          rbyte_q <= mst_rdata;
          fail    <= mst_nack;
          st      <= S_STOP;
        end
        S_STOP: if (op_done) begin
          case (kind)
            K_WR: begin
              rdata_q <= 8'h00;
              err_q   <= fail;
              st      <= S_RESP;
            end
            K_RADR: begin
              kind <= K_RDAT;
              st   <= S_START;
            end
            default: st <= S_DECIDE;
          endcase
        end
        S_DECIDE: begin
          if (retry_again) begin
            kind <= K_RADR;
            st   <= S_PRE;
          end else begin
            rdata_q <= retry_data;
            err_q   <= retry_err;
            st      <= S_RESP;
          end
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte))); // R1
  AST_GUARD_GAP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_START && kind != K_RDAT) |-> guard_idle); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9
  AST_FAIL_DATA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !wr_q && rsp_err) |-> (rsp_rdata == 8'hFF)); // R6
  AST_ACCESS_TOLERATED: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !wr_q && rsp_err) |-> (reg_q != ACC_REG)); // R7
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (rst)
    (op_done && mst_nack && (st == S_SLA || st == S_REG || st == S_DAT))
      |=> (cmd_valid && cmd_op == OP_STOP)); // R8
endmodule

// File: rtl/secreg_i2c_seq.sv
module secreg_i2c_seq #(
  parameter logic [6:0] DEV_ADDR  = 7'h20,
  parameter int         CLK_MHZ   = 50,
  parameter int         GUARD_US  = 250,
  parameter int         TRIES     = 3,
  parameter logic [7:0] FIFO_REG  = 8'h05,
  parameter logic [7:0] ACC_REG   = 8'h00,
  localparam int        GUARD_CYC = CLK_MHZ * GUARD_US
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       rsp_err,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_byte,
  input  logic       mst_done,
  input  logic       mst_nack,
  input  logic [7:0] mst_rdata
);
  logic       guard_idle, guard_arm;
  logic       retry_clr, retry_step, retry_fail, retry_again, retry_err;
  logic [7:0] retry_reg, retry_rbyte, retry_data;

  secreg_guard #(.CYC(GUARD_CYC)) guard_i (
    .clk(clk), .rst(rst), .arm(guard_arm), .idle(guard_idle)
  );

  secreg_retry #(.TRIES(TRIES), .FIFO_REG(FIFO_REG), .ACC_REG(ACC_REG)) retry_i (
    .clk(clk), .rst(rst), .clr(retry_clr), .step(retry_step),
    .reg_addr(retry_reg), .fail(retry_fail), .rbyte(retry_rbyte),
    .again(retry_again), .final_data(retry_data), .final_err(retry_err)
  );

  secreg_xfer #(.DEV_ADDR(DEV_ADDR), .ACC_REG(ACC_REG)) xfer_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .mst_done(mst_done), .mst_nack(mst_nack), .mst_rdata(mst_rdata),
    .guard_idle(guard_idle), .guard_arm(guard_arm),
    .retry_clr(retry_clr), .retry_step(retry_step), .retry_reg(retry_reg),
    .retry_fail(retry_fail), .retry_rbyte(retry_rbyte),
    .retry_again(retry_again), .retry_data(retry_data), .retry_err(retry_err)
  );
endmodule

// File: tb/secreg_i2c_seq_tb_top.sv
module secreg_i2c_seq_tb_top;
  localparam int CLK_MHZ   = 50;
  localparam int GUARD_US  = 2;
  localparam int GUARD_CYC = CLK_MHZ * GUARD_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic       req_ready, rsp_valid, rsp_err, cmd_valid;
  logic [7:0] rsp_rdata, cmd_byte;
  logic [1:0] cmd_op;
  logic       cmd_ready, mst_done, mst_nack;
  logic [7:0] mst_rdata;

  secreg_i2c_seq #(.CLK_MHZ(CLK_MHZ), .GUARD_US(GUARD_US)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .mst_done(mst_done), .mst_nack(mst_nack), .mst_rdata(mst_rdata)
  );

  typedef struct packed { logic [1:0] op; logic [7:0] b; } cmd_t;
  typedef struct packed { logic fail; logic [7:0] val; } att_t;

  cmd_t       exp_cmd[$];
  logic [8:0] exp_rsp[$];
  att_t       att_q[$];
  int         total = 0, bad = 0;
  int         cyc = 0;
  int         wr_nack_at = -1, wr_idx = 0;
  string      cur_tag = "R10";
  bit         done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // ---------- bus master model and command monitor ----------
  logic [1:0] last_op = 2'd3;
  bit         after_start = 0, in_rd = 0, stop_of_rd = 0, have_rd_stop = 0;
  int         start_t = 0, rd_stop_t = 0;
  logic [7:0] cur_val = 8'h00;

  task automatic log_cmd(input logic [1:0] op, input logic [7:0] b,
                         output bit nk, output logic [7:0] rb);
    cmd_t e;
    nk = 0; rb = 8'h00;
    if (exp_cmd.size() == 0) begin
      check(0, cur_tag, "unexpected command", {22'd0, op, b}, 0);
    end else begin
      e = exp_cmd.pop_front();
      check(e.op == op && e.b == b, cur_tag, "command", {22'd0, op, b}, {22'd0, e.op, e.b});
    end
    if (op == 2'd0) begin
      check(last_op == 2'd3, "R2", "START not after STOP", last_op, 3);
      start_t = cyc;
      after_start = 1;
    end else begin
      if (op == 2'd1 && after_start && b == 8'h40 && have_rd_stop) begin
        check(start_t - rd_stop_t >= GUARD_CYC, "R3", "guard gap",
              start_t - rd_stop_t, GUARD_CYC);
        have_rd_stop = 0;
      end
      after_start = 0;
    end
    if (op == 2'd1) begin
      if (b == 8'h41) begin
        att_t a;
        a = (att_q.size() != 0) ? att_q.pop_front() : '0;
        nk = a.fail;
        cur_val = a.val;
        in_rd = 1;
      end else begin
        nk = (wr_idx == wr_nack_at);
        wr_idx++;
      end
    end else if (op == 2'd2) begin
      rb = cur_val;
    end else if (op == 2'd3) begin
      stop_of_rd = in_rd;
      in_rd = 0;
    end
    last_op = op;
  endtask

  initial begin
    int         busy;
    bit         stall_tg, nk;
    logic [7:0] rb;
    busy = 0; stall_tg = 0; nk = 0; rb = 0;
    cmd_ready = 0; mst_done = 0; mst_nack = 0; mst_rdata = 0;
    forever begin
      @(negedge clk);
      mst_done = 0; mst_nack = 0;
      if (cmd_ready) begin
        cmd_ready = 0;
      end else if (busy > 0) begin
        busy--;
        if (busy == 0) begin
          mst_done = 1; mst_nack = nk; mst_rdata = rb;
          if (stop_of_rd) begin
            rd_stop_t = cyc; have_rd_stop = 1; stop_of_rd = 0;
          end
        end
      end else if (cmd_valid && !rst) begin
        if (stall_tg) stall_tg = 0;
        else begin
          stall_tg = 1;
          cmd_ready = 1;
          log_cmd(cmd_op, cmd_byte, nk, rb);
          busy = 2;
        end
      end
    end
  end

  // ---------- response monitor ----------
  initial begin
    bit prev;
    logic [8:0] e;
    prev = 0;
    forever begin
      @(negedge clk);
      if (prev) check(!rsp_valid, "R9", "response longer than one cycle", rsp_valid, 0);
      prev = rsp_valid;
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) check(0, "R9", "unexpected response", rsp_rdata, 0);
        else begin
          e = exp_rsp.pop_front();
          check(rsp_rdata == e[7:0], cur_tag, "rsp data", rsp_rdata, e[7:0]);
          check(rsp_err == e[8], cur_tag, "rsp err", rsp_err, e[8]);
        end
      end
    end
  end

  // ---------- driver ----------
  function automatic void push_c(input logic [1:0] op, input logic [7:0] b);
    cmd_t c;
    c.op = op; c.b = b;
    exp_cmd.push_back(c);
  endfunction

  task automatic do_req(input string tag, input bit wr, input logic [7:0] ra,
                        input logic [7:0] wd, input int nack_at);
    logic [7:0] val;
    bit         fl;
    int         wi;
    wi = 0; val = 8'h00; fl = 0;
    if (wr) begin
      push_c(0, 8'h00);
      push_c(1, 8'h40);
      if (nack_at != 0) begin
        push_c(1, ra);
        if (nack_at != 1) push_c(1, wd);
      end
      push_c(3, 8'h00);
      fl = (nack_at >= 0 && nack_at <= 2);
      exp_rsp.push_back({fl, 8'h00});
    end else begin
      for (int a = 0; a < 3; a++) begin
        push_c(0, 8'h00);
        push_c(1, 8'h40);
        if (wi != nack_at) begin
          wi++;
          push_c(1, ra);
        end
        wi++;
        push_c(3, 8'h00);
        push_c(0, 8'h00);
        push_c(1, 8'h41);
        fl = att_q[a].fail;
        if (!fl) push_c(2, 8'h00);
        push_c(3, 8'h00);
        val = fl ? 8'hFF : att_q[a].val;
        if (val != 8'hFF || ra == 8'h05) break;
      end
      exp_rsp.push_back({fl && (ra != 8'h00), val});
    end
    cur_tag = tag; wr_idx = 0; wr_nack_at = nack_at;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = ra; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R9", "ready while busy", req_ready, 0);
    while (exp_rsp.size() != 0) @(negedge clk);
    check(exp_cmd.size() == 0, tag, "commands left over", exp_cmd.size(), 0);
    check(att_q.size() == 0, tag, "attempts left over", att_q.size(), 0);
    exp_cmd.delete();
    att_q.delete();
  endtask

  function automatic void att(input bit f, input logic [7:0] v);
    att_t a;
    a.fail = f; a.val = v;
    att_q.push_back(a);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);
    check(cmd_valid == 1'b0, "R10", "cmd_valid after reset", cmd_valid, 0);

    do_req("R1", 1, 8'h01, 8'h20, -1);            // plain write
    att(0, 8'h5A);
    do_req("R2", 0, 8'h01, 8'h00, -1);            // read, first try
    do_req("R3", 1, 8'h03, 8'h77, -1);            // write right after a read
    att(0, 8'hFF); att(0, 8'hFF); att(0, 8'h11);
    do_req("R4", 0, 8'h02, 8'h00, -1);            // two retries then data
    att(0, 8'hFF); att(0, 8'hFF); att(0, 8'hFF);
    do_req("R4", 0, 8'h03, 8'h00, -1);            // all ones kept, no error
    att(0, 8'hFF);
    do_req("R5", 0, 8'h05, 8'h00, -1);            // FIFO single attempt
    att(1, 8'h00); att(1, 8'h00); att(1, 8'h00);
    do_req("R6", 0, 8'h01, 8'h00, -1);            // failed read -> FF, err
    att(1, 8'h00); att(1, 8'h00); att(1, 8'h00);
    do_req("R7", 0, 8'h00, 8'h00, -1);            // access reg failure tolerated
    do_req("R8", 1, 8'h04, 8'h99, 2);             // NACK on data byte
    do_req("R8", 1, 8'h04, 8'h99, 0);             // NACK on address byte
    att(1, 8'h00);
    do_req("R5", 0, 8'h05, 8'h00, -1);            // FIFO failure, no retry
    att(0, 8'h33);
    do_req("R8", 0, 8'h06, 8'h00, 1);             // address-phase NACK, read goes on
    att(1, 8'h00); att(0, 8'h42);
    do_req("R4", 0, 8'h07, 8'h00, -1);            // failure then success

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule